// File: doc/BRIEF.md
# Credit-Flow Message Thread Hub

The hub holds a parameterized set of one-way message threads that software drives through a simple register bus. Each thread owns a 4 KB page. The page holds a status word and fifteen 32-bit data words, which together carry one 60-byte message. Thread t is paired with thread t^1 in a loopback. A message sent on one thread of a pair lands in the receive buffer of the other thread. A second address region, chosen by a select input, holds one control word per thread. Bit 31 of that control word sets the thread's direction.

The meaning of the count field in the status word depends on the direction. A transmit thread reports how many more messages it may send, which is its credit toward the paired buffer. A receive thread reports how many messages are waiting to be read. A send with no credit left puts the thread into a fault state. While faulted, the thread ignores its message traffic until software clears the fault. Each receive thread drives an interrupt while it has messages pending.

Top module: `sproxy_hub`

## Requirements
- R1: In the data region, thread t's page starts at byte address 0x1000*t. The status word is at page offset 0 and data word n (0..14) is at offset 4+4n. With bus_ctrl_sel high, the control word of thread t is at 0x1000*(t+1). Read data appears on bus_rdata one clock after the read request. A read of any other address returns 0.
- R2: After reset every error flag is 0 and every buffer is empty. Even-numbered threads reset to transmit (control bit 31 = 0) and odd-numbered threads reset to receive (control bit 31 = 1). A transmit thread therefore reports a credit of DEPTH.
- R3: The status word carries the count in bits 7:0 and the error flag in bit 31, with all other bits 0. For a receive thread the count is the number of messages in its own buffer. For a transmit thread it is DEPTH minus the occupancy of thread t^1's buffer. Writing control bit 31 sets the direction, and reading the control word returns it in bit 31.
- R4: On a transmit thread with credit, a write to data word 14 delivers a 15-word message into thread t^1's buffer. Words 0..13 come from the earlier writes and word 14 is the written value. The staging words are cleared after each send, so words that were not written arrive as 0.
- R5: A buffer holds up to DEPTH messages and returns them in send order. A read of data word n on a receive thread returns word n of the oldest message. A read of word 14 also removes that message, which returns one credit to the sender.
- R6: A data read returns 0 and changes nothing when the thread is transmit or its buffer is empty. A read of word 14 under either condition removes nothing.
- R7: A send on a transmit thread with zero credit sets that thread's error bit and discards the message. The receive buffer is left unchanged.
- R8: While a thread's error bit is set, its data writes and sends are ignored and its data reads return 0 without consuming. Writing the status word with bit 31 = 1 clears the error bit.
- R9: rx_irq[t] is high exactly when thread t is receive and its pending count is nonzero.
- R10: Data writes to a receive thread are ignored. This includes writes to word 14, which send nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ctrl_sel | input | 1 | 0 = thread data/status region, 1 = control region |
| bus_addr | input | ADDR_W | Byte address within the selected region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid one cycle after a read request |
| rx_irq | output | THREADS | Per-thread receive interrupt |

## Verification
The buffer assertions rely on the bus never pushing into a full buffer and never popping an empty one. The hub guarantees this itself, because it gates sends with the credit and gates consumes with the pending count. The stimulus therefore does not hold back on purpose. It sends freely on threads with no credit, reads empty buffers, and flips directions in the middle of a run. These are exactly the cases where a missing gate would trip an assertion. The bus carries one access per clock, so a buffer is never pushed and popped in the same cycle, and the bench keeps to that by issuing one request per cycle.

// File: rtl/sproxy_pkg.sv
`timescale 1ns/1ps
package sproxy_pkg;

    localparam int WORD_W     = 32;
    localparam int MSG_WORDS  = 15;
    localparam int LAST_WORD  = MSG_WORDS - 1;
    localparam int PAGE_SHIFT = 12;
    localparam int FLAG_BIT   = 31;
    localparam int CNT_FIELD  = 8;

    typedef logic [WORD_W-1:0]     word_t;
    typedef word_t [MSG_WORDS-1:0] msg_t;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_DATA   = 2'd2,
        ACC_CTRL   = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e   kind;
        logic        we;
        logic [7:0]  thread;
        logic [3:0]  word;
    } access_t;

    function automatic word_t status_word(input logic err, input logic [CNT_FIELD-1:0] cnt);
        return {err, {(WORD_W-CNT_FIELD-1){1'b0}}, cnt};
    endfunction

endpackage

// File: rtl/sproxy_decode.sv
`timescale 1ns/1ps
module sproxy_decode
    import sproxy_pkg::*;
#(
    parameter int THREADS = 4,
    parameter int ADDR_W  = PAGE_SHIFT + $clog2(THREADS + 1)
) (
    input  logic              en,
    input  logic              we,
    input  logic              ctrl_sel,
    input  logic [ADDR_W-1:0] addr,
    output access_t           acc
);
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
    localparam logic [PAGE_W-1:0] NUM_PAGES = PAGE_W'(THREADS);

    logic [PAGE_W-1:0]     page;
    logic [PAGE_SHIFT-1:0] off;

    assign page = addr[ADDR_W-1:PAGE_SHIFT];
    assign off  = addr[PAGE_SHIFT-1:0];

    always_comb begin
        acc        = '0;
        acc.kind   = ACC_NONE;
        acc.we     = we;
        if (en) begin
            if (!ctrl_sel) begin
                if (page < NUM_PAGES) begin
                    acc.thread = 8'(page);
                    if (off == '0) begin
                        acc.kind = ACC_STATUS;
                    end else if (off[PAGE_SHIFT-1:6] == '0 && off[1:0] == 2'b00 && off[5:2] != 4'd0) begin
                        acc.kind = ACC_DATA;
                        acc.word = off[5:2] - 4'd1;
                    end
                end
            end else begin
                if (page != '0 && page <= NUM_PAGES && off == '0) begin
                    acc.kind   = ACC_CTRL;
                    acc.thread = 8'(page - PAGE_W'(1));
                end
            end
        end
    end
endmodule

// File: rtl/sproxy_fifo.sv
`timescale 1ns/1ps
module sproxy_fifo
    import sproxy_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  msg_t                       push_msg,
    input  logic                       pop,
    output msg_t                       head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    msg_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_msg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rd_ptr];

    // Credit gating upstream must stop a push into a full buffer (R5)
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (count != CNT_W'(DEPTH)));

    // Pending gating upstream must stop a pop of an empty buffer (R6)
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));
endmodule

// File: rtl/sproxy_thread.sv
`timescale 1ns/1ps
module sproxy_thread
    import sproxy_pkg::*;
#(
    parameter int THREAD_ID = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    hit,
    input  access_t acc,
    input  word_t   wdata,
    input  logic    credit_ok,
    input  logic    pend_nz,
    output logic    dir_rx,
    output logic    err,
    output logic    send,
    output msg_t    send_msg,
    output logic    consume
);
    localparam logic RESET_DIR = 1'(THREAD_ID % 2);

    msg_t stage_q;
    logic data_wr, send_req, overflow, err_clr, ctrl_wr, last_word;

    assign last_word = (acc.word == 4'(LAST_WORD));
    assign data_wr   = hit && acc.we && acc.kind == ACC_DATA && !err && !dir_rx;
    assign send_req  = data_wr && last_word;
    assign send      = send_req && credit_ok;
    assign overflow  = send_req && !credit_ok;
    assign err_clr   = hit && acc.we && acc.kind == ACC_STATUS && wdata[FLAG_BIT];
    assign ctrl_wr   = hit && acc.we && acc.kind == ACC_CTRL;
    assign consume   = hit && !acc.we && acc.kind == ACC_DATA && last_word
                       && dir_rx && !err && pend_nz;

    always_comb begin
        send_msg            = stage_q;
        send_msg[LAST_WORD] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            err     <= 1'b0;
            dir_rx  <= RESET_DIR;
        end else begin
            if (send_req)      stage_q <= '0;
            else if (data_wr)  stage_q[acc.word] <= wdata;
            if (overflow)      err <= 1'b1;
            else if (err_clr)  err <= 1'b0;
            if (ctrl_wr)       dir_rx <= wdata[FLAG_BIT];
        end
    end

    // Staging is empty after every send attempt, so unwritten words go out as zero (R4)
    assert_stage_cleared_R4: assert property (@(posedge clk) disable iff (rst)
        send_req |=> (stage_q == '0));

    // The fault flag only rises after a send that found no credit (R7)
    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(send_req && !credit_ok));
endmodule

// File: rtl/sproxy_hub.sv
`timescale 1ns/1ps
module sproxy_hub
    import sproxy_pkg::*;
#(
    parameter int THREADS = 4,
    parameter int DEPTH   = 4,
    parameter int ADDR_W  = PAGE_SHIFT + $clog2(THREADS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic               bus_ctrl_sel,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [THREADS-1:0] rx_irq
);
    localparam int TIDX_W = (THREADS > 1) ? $clog2(THREADS) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    access_t            acc;
    logic [THREADS-1:0] hit, send, consume, dir_rx, err, credit_ok, pend_nz;
    msg_t               send_msg [THREADS];
    msg_t               head     [THREADS];
    logic [CNT_W-1:0]   cnt      [THREADS];
    word_t              status   [THREADS];
    word_t              rd_next;
    logic [TIDX_W-1:0]  tsel;

    sproxy_decode #(.THREADS(THREADS), .ADDR_W(ADDR_W)) u_decode (
        .en       (bus_en),
        .we       (bus_we),
        .ctrl_sel (bus_ctrl_sel),
        .addr     (bus_addr),
        .acc      (acc)
    );

    for (genvar i = 0; i < THREADS; i++) begin : g_thr
        localparam int PEER = i ^ 1;

        assign hit[i]       = (acc.kind != ACC_NONE) && (acc.thread == 8'(i));
        assign credit_ok[i] = (cnt[PEER] != FULL);
        assign pend_nz[i]   = (cnt[i] != '0);
        assign rx_irq[i]    = dir_rx[i] && pend_nz[i];
        assign status[i]    = status_word(err[i],
                                  dir_rx[i] ? CNT_FIELD'(cnt[i]) : CNT_FIELD'(FULL - cnt[PEER]));

        sproxy_thread #(.THREAD_ID(i)) u_thread (
            .clk       (clk),
            .rst       (rst),
            .hit       (hit[i]),
            .acc       (acc),
            .wdata     (bus_wdata),
            .credit_ok (credit_ok[i]),
            .pend_nz   (pend_nz[i]),
            .dir_rx    (dir_rx[i]),
            .err       (err[i]),
            .send      (send[i]),
            .send_msg  (send_msg[i]),
            .consume   (consume[i])
        );

        sproxy_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst      (rst),
            .push     (send[PEER]),
            .push_msg (send_msg[PEER]),
            .pop      (consume[i]),
            .head     (head[i]),
            .count    (cnt[i])
        );

        // A faulted sender never adds to its peer's buffer (R8)
        assert_fault_blocks_send_R8: assert property (@(posedge clk) disable iff (rst)
            err[i] |=> (cnt[PEER] <= $past(cnt[PEER])));
    end

    assign tsel = acc.thread[TIDX_W-1:0];

    always_comb begin
        case (acc.kind)
            ACC_STATUS: rd_next = status[tsel];
            ACC_CTRL:   rd_next = {dir_rx[tsel], 31'd0};
            ACC_DATA:   rd_next = (dir_rx[tsel] && !err[tsel] && pend_nz[tsel])
                                  ? head[tsel][acc.word] : '0;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                   bus_rdata <= '0;
        else if (bus_en && !bus_we) bus_rdata <= rd_next;
    end
endmodule

// File: tb/sim_sproxy_hub.sv
`timescale 1ns/1ps
module sim_sproxy_hub;
    localparam int T  = 4;
    localparam int D  = 4;
    localparam int AW = 12 + $clog2(T + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_en = 1'b0, bus_we = 1'b0, bus_ctrl_sel = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [T-1:0]  rx_irq;

    always #2.5 clk = ~clk;

    sproxy_hub #(.THREADS(T), .DEPTH(D)) u0 (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_ctrl_sel(bus_ctrl_sel), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_irq(rx_irq)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    bit          m_dir [T];
    bit          m_err [T];
    int          m_cnt [T];
    int          m_head[T];
    logic [31:0] m_stage[T][15];
    logic [31:0] m_fifo [T][D][15];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] page_addr(input int pg, input int off);
        return AW'(pg * 4096 + off);
    endfunction

    task automatic bus_op(input bit ctrl, input bit we, input logic [AW-1:0] a,
                          input logic [31:0] wd, output logic [31:0] rd);
        bus_en = 1'b1; bus_we = we; bus_ctrl_sel = ctrl; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        rd = bus_rdata;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    function automatic logic [31:0] exp_status(input int t);
        logic [7:0] c = m_dir[t] ? 8'(m_cnt[t]) : 8'(D - m_cnt[t ^ 1]);
        return {m_err[t], 23'd0, c};
    endfunction

    task automatic wr_data(input int t, input int w, input logic [31:0] v);
        logic [31:0] rd;
        int p, slot;
        bus_op(0, 1, page_addr(t, 4 + 4 * w), v, rd);
        if (!m_dir[t] && !m_err[t]) begin
            if (w == 14) begin
                p = t ^ 1;
                if (m_cnt[p] == D) m_err[t] = 1;
                else begin
                    slot = (m_head[p] + m_cnt[p]) % D;
                    for (int k = 0; k < 14; k++) m_fifo[p][slot][k] = m_stage[t][k];
                    m_fifo[p][slot][14] = v;
                    m_cnt[p]++;
                end
                for (int k = 0; k < 15; k++) m_stage[t][k] = '0;
            end else m_stage[t][w] = v;
        end
    endtask

    task automatic rd_data(input int t, input int w, input string req);
        logic [31:0] rd, exp;
        bit live = m_dir[t] && !m_err[t] && m_cnt[t] > 0;
        exp = live ? m_fifo[t][m_head[t]][w] : 32'd0;
        bus_op(0, 0, page_addr(t, 4 + 4 * w), 0, rd);
        chk(req, rd, exp);
        if (live && w == 14) begin
            m_head[t] = (m_head[t] + 1) % D;
            m_cnt[t]--;
        end
    endtask

    task automatic rd_status(input int t, input string req);
        logic [31:0] rd;
        bus_op(0, 0, page_addr(t, 0), 0, rd);
        chk(req, rd, exp_status(t));
    endtask

    task automatic rd_ctrl(input int t, input string req);
        logic [31:0] rd;
        bus_op(1, 0, page_addr(t + 1, 0), 0, rd);
        chk(req, rd, {m_dir[t], 31'd0});
    endtask

    task automatic wr_ctrl(input int t, input logic [31:0] v);
        logic [31:0] rd;
        bus_op(1, 1, page_addr(t + 1, 0), v, rd);
        m_dir[t] = v[31];
    endtask

    task automatic wr_status(input int t, input logic [31:0] v);
        logic [31:0] rd;
        bus_op(0, 1, page_addr(t, 0), v, rd);
        if (v[31]) m_err[t] = 0;
    endtask

    task automatic irq_check(input string req);
        for (int t = 0; t < T; t++) chk(req, 32'(rx_irq[t]), 32'(m_dir[t] && m_cnt[t] != 0));
    endtask

    task automatic send_msg(input int t, input logic [31:0] base);
        for (int w = 0; w < 15; w++) wr_data(t, w, base + 32'(w));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int r, t, w;
        for (int i = 0; i < T; i++) begin
            m_dir[i] = bit'(i % 2); m_err[i] = 0; m_cnt[i] = 0; m_head[i] = 0;
            for (int k = 0; k < 15; k++) m_stage[i][k] = '0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R2 reset state, R3 status encoding
        for (int i = 0; i < T; i++) begin
            rd_status(i, "R2 reset status");
            rd_ctrl(i, "R2 reset direction");
        end
        irq_check("R9 reset irq");

        // R1 unmapped offsets read 0
        bus_op(0, 0, page_addr(0, 12'h800), 0, rd); chk("R1 unmapped status page", rd, 0);
        bus_op(0, 0, page_addr(1, 64), 0, rd);      chk("R1 beyond last word", rd, 0);
        bus_op(1, 0, page_addr(0, 0), 0, rd);       chk("R1 control page zero", rd, 0);

        // R4 full message, R3 counts, R9 irq, R5 readout
        send_msg(0, 32'hA000_0000);
        rd_status(0, "R3 credit after send");
        rd_status(1, "R3 pending after send");
        irq_check("R9 irq pending");
        for (int k = 0; k < 15; k++) rd_data(1, k, "R5 word readout");
        rd_status(0, "R5 credit returned");
        irq_check("R9 irq cleared");

        // R4 partial message: unwritten words zero
        wr_data(0, 2, 32'h1234_5678);
        wr_data(0, 14, 32'hCAFE_0001);
        wr_data(0, 14, 32'hCAFE_0002);
        for (int k = 0; k < 15; k++) rd_data(1, k, "R4 partial message");
        for (int k = 0; k < 15; k++) rd_data(1, k, "R4 staging cleared");

        // R6 empty read and transmit-side read
        rd_data(1, 14, "R6 consume on empty");
        rd_data(0, 3, "R6 data read on transmit thread");
        rd_status(1, "R6 empty after null consume");

        // R7 overflow, R8 fault behaviour
        for (int m = 0; m < D; m++) send_msg(0, 32'hB000_0000 + 32'(m << 8));
        rd_status(0, "R7 zero credit");
        send_msg(0, 32'hDEAD_0000);
        rd_status(0, "R7 error bit set");
        rd_status(1, "R7 message discarded");
        send_msg(0, 32'hDEAD_1000);
        rd_status(1, "R8 faulted send ignored");
        wr_ctrl(1, 32'h0);
        wr_ctrl(0, 32'h8000_0000);
        rd_data(0, 14, "R8 faulted read returns zero");
        wr_ctrl(0, 32'h0);
        wr_ctrl(1, 32'h8000_0000);
        wr_status(0, 32'h0000_00FF);
        rd_status(0, "R8 clear needs bit 31");
        wr_status(0, 32'h8000_0000);
        rd_status(0, "R8 error cleared");
        for (int m = 0; m < D; m++) rd_data(1, 14, "R5 order after fill");
        rd_status(0, "R5 credit refilled");

        // R10 writes on receive thread ignored
        wr_data(1, 14, 32'h5555_5555);
        rd_status(0, "R10 no message from receive thread");
        rd_status(1, "R10 receive count unchanged");

        // R3 direction swap on second pair
        wr_ctrl(2, 32'h8000_0000);
        wr_ctrl(3, 32'h0);
        rd_ctrl(2, "R3 direction read back");
        send_msg(3, 32'hC000_0000);
        rd_status(2, "R3 swapped receive count");
        rd_status(3, "R3 swapped credit");
        irq_check("R9 swapped irq");

        // Random traffic
        r = $urandom(32'h5EED_0042);
        for (int n = 0; n < 4000; n++) begin
            t = $urandom % T;
            r = $urandom % 100;
            if (r < 35) begin
                w = ($urandom % 3 == 0) ? 14 : $urandom % 14;
                wr_data(t, w, $urandom);
            end else if (r < 55) rd_data(t, $urandom % 15, "R5 random read");
            else if (r < 67)     rd_data(t, 14, "R6 random consume");
            else if (r < 82)     rd_status(t, "R3 random status");
            else if (r < 87)     wr_status(t, {1'b1, 31'($urandom)});
            else if (r < 89)     wr_ctrl(t, {1'($urandom), 31'd0});
            else                 rd_ctrl(t, "R3 random control");
            irq_check("R9 random irq");
        end
        for (int i = 0; i < T; i++) rd_status(i, "R7 final status");
        finish_run();
    end
endmodule